// File: doc/BRIEF.md
# Multi-Lane Peak Detector with Time-of-Flight

The block watches a wide stream of correlation results. Each accepted word holds several samples side by side, eight 16-bit lanes by default. At 500 MHz this covers a 4 GSPS sample stream. For every sample it decides whether that sample is a genuine pulse peak. A genuine peak is a local maximum in stream order that also sits strictly above a fixed threshold. For every lane it emits one of two things: the sample's time-of-flight index since the last fire pulse, or zero. One index count corresponds to one sample period, which is roughly 4 cm of range. A lane's neighbours are always its true stream neighbours. Lane 0 compares against the last lane of the previous word, and the last lane compares against lane 0 of the following word.

The input side carries only a valid qualifier and has no ready. The sample source is a converter that cannot pause, so the block never applies back-pressure and accepts every word presented with `in_valid`. The output side has the same form: `out_valid` marks each result word, and the consumer must take that word in the same cycle. Judging the last lane needs the first sample of the next word. Each word is therefore held as the centre word until its successor arrives, and its result appears in the cycle after that successor is accepted. The `fire` input marks the laser shot: it restarts the sample index. The emitted index of a lane is the word's base index plus the lane number. The index saturates at its all-ones value, and the value 0 means "no detection".

Top module: `tof_peak_detect`

## Requirements
- R1: During and straight after reset, `out_valid` is 0 and `out_data` is all zero.
- R2: A word accepted while a previous word is held produces exactly one result word, for that previous word. The result appears with `out_valid` high in the cycle after the acceptance. The first word after reset produces no result.
- R3: A lane reports only if its centre sample is strictly greater than `THRESH`. Samples are compared as two's-complement values when `DATA_SIGNED` is 1 and as unsigned values otherwise.
- R4: A lane reports only if its centre is strictly greater than the previous sample and greater than or equal to the next sample. On a flat top of two equal samples, only the earlier one reports.
- R5: Neighbours follow stream order across word edges. Lane 0's previous sample is the last lane of the previously accepted word, or 0 after reset. The last lane's next sample is lane 0 of the following accepted word.
- R6: A reporting lane i of a word whose base index is b emits b + i. Lane i occupies bits [W*i+W-1 : W*i] of `out_data`.
- R7: A word accepted in the cycle `fire` is high gets base index 0. Each later accepted word gets a base LANES above the previous one. A `fire` pulse with no accepted word makes the next accepted word start at 0. Cycles with `in_valid` low do not advance the index.
- R8: Both the base index and each lane's emitted index saturate at the all-ones value of W bits and never wrap.
- R9: A lane that does not report outputs 0, and `out_data` is all zero whenever `out_valid` is low.
- R10: Cycles with `in_valid` low leave the held words untouched and produce no result. A peak that straddles an idle gap is judged as if the gap were absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire | input | 1 | Shot marker; restarts the sample index |
| in_valid | input | 1 | Input word present this cycle; always accepted |
| in_data | input | LANES*W | Correlation samples, lane i at bits W*i upward |
| out_valid | output | 1 | Result word present; must be taken this cycle |
| out_data | output | LANES*W | Per-lane time-of-flight index or zero |

## Verification
The bench builds the block with four 8-bit lanes, signed data and a threshold of 20. With this configuration every sample value of a lane can be swept against the threshold, including the negative codes that would pass an unsigned compare. A single pulse and a two-sample plateau can be walked through every stream position across three words. Because the index is only 8 bits wide, it saturates after 64 words, so the saturation corner is reached by a short stream. A long pseudo-random run then draws samples from a small alphabet close to the threshold. It mixes idle gaps and fire pulses into that stream and compares every result word against an arithmetic model of the stream.

// File: rtl/tof_peak_pkg.sv
package tof_peak_pkg;

  // Saturating addition of a small unsigned offset to a W-bit index,
  // performed at 32 bits; callers keep W below 31.
  function automatic int unsigned sat_index(int unsigned base, int unsigned offs,
                                            int unsigned maxv);
    int unsigned s;
    s = base + offs;
    return (s > maxv) ? maxv : s;
  endfunction

endpackage

// File: rtl/tof_base_counter.sv
module tof_base_counter #(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         adv,
  output logic [W-1:0] base_o
);
  import tof_peak_pkg::*;

  localparam int unsigned MAXV = (1 << W) - 1;

  logic [W-1:0] next_q;
  logic [W-1:0] next_d;

  // Base for the word accepted in this cycle.
  assign base_o = fire ? '0 : next_q;
  assign next_d = W'(sat_index(int'(base_o), LANES, MAXV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q <= '0;
    end else if (adv) begin
      next_q <= next_d;
    end else if (fire) begin
      next_q <= '0;
    end
  end

endmodule

// File: rtl/lane_window.sv
module lane_window #(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input  logic [LANES*W-1:0] centre_i,
  input  logic [W-1:0]       carry_i,
  input  logic [W-1:0]       follow_i,
  output logic [LANES*W-1:0] prev_o,
  output logic [LANES*W-1:0] next_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign prev_o[0 +: W] = carry_i;
    end else begin : g_inner_prev
      assign prev_o[g*W +: W] = centre_i[(g-1)*W +: W];
    end
    if (g == LANES-1) begin : g_last
      assign next_o[g*W +: W] = follow_i;
    end else begin : g_inner_next
      assign next_o[g*W +: W] = centre_i[(g+1)*W +: W];
    end
  end

endmodule

// File: rtl/peak_lane.sv
module peak_lane #(
  parameter int W           = 16,
  parameter int THRESH      = 1024,
  parameter bit DATA_SIGNED = 1'b1,
  parameter int IDX         = 0
) (
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] centre_i,
  input  logic [W-1:0] next_i,
  input  logic [W-1:0] base_i,
  output logic [W-1:0] value_o
);
  import tof_peak_pkg::*;

  localparam int unsigned MAXV = (1 << W) - 1;

  logic above;
  logic over_prev;
  logic holds_next;
  logic [W-1:0] index;

  if (DATA_SIGNED) begin : g_signed
    assign above      = int'($signed(centre_i)) > THRESH;
    assign over_prev  = $signed(centre_i) > $signed(prev_i);
    assign holds_next = $signed(centre_i) >= $signed(next_i);
  end else begin : g_unsigned
    assign above      = int'({1'b0, centre_i}) > THRESH;
    assign over_prev  = centre_i > prev_i;
    assign holds_next = centre_i >= next_i;
  end

  assign index   = W'(sat_index(int'(base_i), IDX, MAXV));
  assign value_o = (above && over_prev && holds_next) ? index : '0;

endmodule

// File: rtl/tof_peak_detect.sv
module tof_peak_detect #(
  parameter int LANES       = 8,
  parameter int W           = 16,
  parameter int THRESH      = 1024,
  parameter bit DATA_SIGNED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic               in_valid,
  input  logic [LANES*W-1:0] in_data,
  output logic               out_valid,
  output logic [LANES*W-1:0] out_data
);

  localparam int DW = LANES * W;

  logic [DW-1:0] centre_q;
  logic [W-1:0]  carry_q;
  logic [W-1:0]  cbase_q;
  logic          have_q;
  logic [W-1:0]  word_base;
  logic [DW-1:0] prev_v;
  logic [DW-1:0] next_v;
  logic [DW-1:0] hit_v;
  logic          emit;

  tof_base_counter #(.LANES(LANES), .W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .adv    (in_valid),
    .base_o (word_base)
  );

  lane_window #(.LANES(LANES), .W(W)) u_win (
    .centre_i (centre_q),
    .carry_i  (carry_q),
    .follow_i (in_data[W-1:0]),
    .prev_o   (prev_v),
    .next_o   (next_v)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_pk
    peak_lane #(
      .W(W), .THRESH(THRESH), .DATA_SIGNED(DATA_SIGNED), .IDX(g)
    ) u_lane (
      .prev_i   (prev_v[g*W +: W]),
      .centre_i (centre_q[g*W +: W]),
      .next_i   (next_v[g*W +: W]),
      .base_i   (cbase_q),
      .value_o  (hit_v[g*W +: W])
    );
  end

  assign emit = in_valid && have_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      centre_q  <= '0;
      carry_q   <= '0;
      cbase_q   <= '0;
      have_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_valid) begin
        carry_q  <= centre_q[DW-1 -: W];
        centre_q <= in_data;
        cbase_q  <= word_base;
        have_q   <= 1'b1;
      end
      out_valid <= emit;
      out_data  <= emit ? hit_v : '0;
    end
  end

endmodule

// File: rtl/tof_peak_chk.sv
module tof_peak_chk #(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_valid,
  input logic [LANES*W-1:0] out_data
);

  p_out_needs_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_quiet_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

  p_idle_no_output_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  for (genvar g = 0; g < LANES; g++) begin : g_ck
    p_lane_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_data[g*W +: W] != '0 && out_data[g*W +: W] != '1)
        |-> ((int'(out_data[g*W +: W]) % LANES) == g));
    if (g > 0) begin : g_adj
      p_no_adjacent_peaks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_data[g*W +: W] != '0 && out_data[(g-1)*W +: W] != '0));
    end
  end

endmodule

bind tof_peak_detect tof_peak_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_tof_peak_detect.sv
module sim_tof_peak_detect;
  localparam int L    = 4;
  localparam int W    = 8;
  localparam int T    = 20;
  localparam int DW   = L * W;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fire = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  tof_peak_detect #(.LANES(L), .W(W), .THRESH(T), .DATA_SIGNED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .fire(fire), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  string req = "R1";

  logic [DW-1:0] m_cur = '0;
  logic [W-1:0]  m_pl = '0;
  int            m_cb = 0;
  int            m_nb = 0;
  bit            m_have = 1'b0;
  bit            pend_v = 1'b0;
  logic [DW-1:0] pend_d = '0;
  int unsigned   lcg = 32'h1234_5678;

  function automatic int sat(int x);
    return (x > MAXV) ? MAXV : x;
  endfunction

  function automatic int sv(logic [W-1:0] x);
    return int'($signed(x));
  endfunction

  function automatic logic [DW-1:0] put(logic [DW-1:0] w, int lane, int val);
    logic [DW-1:0] r;
    r = w;
    r[lane*W +: W] = W'(val);
    return r;
  endfunction

  // Expected result word from R3..R6, R8, R9
  function automatic logic [DW-1:0] expect_word(logic [DW-1:0] c, logic [W-1:0] pl,
                                                logic [DW-1:0] n, int cb);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < L; i++) begin
      int cv;
      int pv;
      int nv;
      cv = sv(c[i*W +: W]);
      pv = (i == 0) ? sv(pl) : sv(c[(i-1)*W +: W]);
      nv = (i == L-1) ? sv(n[0 +: W]) : sv(c[(i+1)*W +: W]);
      if (cv > T && cv > pv && cv >= nv) r[i*W +: W] = W'(sat(cb + i));
    end
    return r;
  endfunction

  task automatic check_out();
    n_chk++;
    if (out_valid !== pend_v || out_data !== pend_d) begin
      n_bad++;
      $display("FAIL %s: out_valid=%0b out_data=%h expected out_valid=%0b out_data=%h",
               req, out_valid, out_data, pend_v, pend_d);
    end
  endtask

  task automatic step(bit v, bit f, logic [DW-1:0] w);
    @(negedge clk);
    check_out();
    in_valid = v;
    fire     = f;
    in_data  = w;
    if (v) begin
      int wb;
      wb     = f ? 0 : m_nb;
      pend_v = m_have;
      pend_d = m_have ? expect_word(m_cur, m_pl, w, m_cb) : '0;
      m_pl   = m_cur[DW-1 -: W];
      m_cur  = w;
      m_cb   = wb;
      m_have = 1'b1;
      m_nb   = sat(wb + L);
    end else begin
      pend_v = 1'b0;
      pend_d = '0;
      if (f) m_nb = 0;
    end
  endtask

  function automatic int pick();
    int tbl [4] = '{-3, 19, 21, 40};
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return tbl[(lcg >> 16) & 3];
  endfunction

  initial begin
    // R1: reset state
    req = "R1";
    repeat (3) begin
      @(negedge clk);
      check_out();
    end
    rst_n = 1'b1;

    // R5: single pulse walked through every position of three words
    for (int p = 0; p < 3*L; p++) begin
      for (int k = 0; k < 2; k++) begin
        logic [3*DW-1:0] s;
        req = (k == 0) ? "R5" : "R4";
        s = '0;
        s[p*W +: W] = W'(50);
        if (k == 1 && p + 1 < 3*L) s[(p+1)*W +: W] = W'(50);
        step(1'b1, 1'b0, s[0 +: DW]);
        step(1'b1, 1'b0, s[DW +: DW]);
        step(1'b1, 1'b0, s[2*DW +: DW]);
        step(1'b1, 1'b0, '0);
      end
    end

    // R3: every sample code against the threshold, neighbours zero
    req = "R3";
    for (int v = -128; v < 128; v++) begin
      step(1'b1, 1'b0, put('0, 1, v));
      step(1'b1, 1'b0, '0);
    end

    // R4: centre against equal, lower and higher neighbours
    req = "R4";
    for (int a = 49; a <= 51; a++) begin
      for (int b = 49; b <= 51; b++) begin
        step(1'b1, 1'b0, put(put(put('0, 0, a), 1, 50), 2, b));
        step(1'b1, 1'b0, '0);
      end
    end

    // R10: idle gaps across a word edge
    req = "R10";
    for (int b = 49; b <= 51; b++) begin
      step(1'b1, 1'b0, put('0, L-1, 50));
      repeat (3) step(1'b0, 1'b0, put('0, 0, 99));
      step(1'b1, 1'b0, put('0, 0, b));
      step(1'b1, 1'b0, '0);
    end

    // R7: fire with a word, fire while idle, fire mid-stream
    req = "R7";
    step(1'b1, 1'b1, put('0, 2, 60));
    step(1'b1, 1'b0, put('0, 1, 60));
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    step(1'b1, 1'b0, put('0, 3, 60));
    step(1'b1, 1'b0, put('0, 2, 60));
    step(1'b1, 1'b1, put('0, 0, 60));
    step(1'b1, 1'b0, put('0, 1, 60));

    // R6: peaks on each lane over successive words
    req = "R6";
    for (int i = 0; i < 2*L; i++) step(1'b1, 1'b0, put('0, i % L, 70));

    // R9: rising ramp above threshold, no local maxima
    req = "R9";
    for (int i = 0; i < 6; i++) begin
      logic [DW-1:0] w;
      w = '0;
      for (int j = 0; j < L; j++) w = put(w, j, 30 + 4*i + j);
      step(1'b1, 1'b0, w);
    end

    // R8: index saturation
    req = "R8";
    step(1'b1, 1'b1, put('0, 2, 50));
    for (int i = 0; i < 80; i++) step(1'b1, 1'b0, put(put('0, 2, 50), 3, 51));

    // R2: pseudo-random stream with gaps and fires
    req = "R2";
    step(1'b1, 1'b1, '0);
    for (int i = 0; i < 600; i++) begin
      logic [DW-1:0] w;
      bit v;
      bit f;
      w = '0;
      for (int j = 0; j < L; j++) w = put(w, j, pick());
      v = ((lcg >> 8) % 5) != 0;
      f = ((lcg >> 4) % 97) == 0;
      step(v, f, w);
    end
    step(1'b0, 1'b0, '0);
    @(negedge clk);
    check_out();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog in %s: run still active after 200000 cycles, expected completion", req);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule